// File: doc/BRIEF.md
# Superframe multiplexer

This block builds the transmit byte stream of a multi-channel DSL link. Three byte-wide payload channels feed it through valid/ready handshakes. A high-rate simplex channel supplies 48 bytes per frame and a low-rate control channel supplies one byte on every second frame; both go to the interleaved buffer. A duplex channel supplies 5 bytes per frame to the fast buffer. Each pulse of the frame tick input starts one frame slot. In that slot the block emits the fast part and then the interleaved part, one byte per clock, on a single registered byte output. The output carries markers for frame start, superframe start and the synchronisation frame.

Frames are counted from 0 to 68. Frames 0 to 67 carry data. Frame 68 is the synchronisation frame, and the count then wraps. In frames 0, 1, 34 and 35 the two overhead positions carry the CRC/indicator bytes that a side input presents. All other frames put a constant filler in those positions. If a payload channel is due but has no byte ready, the block sends 0x00 in its place and latches an underrun flag. Scrambling, CRC generation, error correction and interleaving are done by other blocks.

Top module: `sf_mux`

## Requirements
- R1: After reset, byte_valid_o, the three ready outputs and underrun_o are low. The first frame after reset is frame 0 of a new superframe.
- R2: A frame_tick_i pulse while idle starts one frame of exactly 59 consecutive valid bytes. frame_start_o is high on the first byte only. A tick that arrives while a frame is in progress is ignored.
- R3: The fast part (byte positions 0 to 6) is one overhead byte, then 5 duplex-channel bytes in arrival order, then the constant TAIL_L_BYTE (default 0x5A).
- R4: The interleaved part (byte positions 7 to 58) is one overhead byte, then 48 simplex-channel bytes in arrival order, then the control slot, then TAIL_A_BYTE (default 0xA5), then TAIL_L_BYTE.
- R5: The control slot carries one control-channel byte in even-numbered data frames. In odd-numbered frames the slot is 0x00 and ct_ready_o stays low.
- R6: In frames 0, 1, 34 and 35, position 0 carries ovh_fast_i and position 7 carries ovh_intl_i. In the other data frames both positions carry SYNC_FILL (default 0x3C).
- R7: Frame 68 is the synchronisation frame. All 59 of its bytes are 0x00, sync_frame_o is high on each of them, and no channel is offered ready.
- R8: sf_start_o is high only on the first byte of frame 0. After frame 68 the next frame is frame 0 again.
- R9: If a channel is offered ready in a slot where it is due and its valid is low, the slot's byte is 0x00 and underrun_o rises and stays high until reset.
- R10: At most one ready output is high in any cycle. A byte is consumed only when valid and ready are both high, and it appears on byte_o one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick_i | input | 1 | Frame strobe, one pulse per frame slot |
| sx_data_i | input | 8 | Simplex channel byte |
| sx_valid_i | input | 1 | Simplex channel byte available |
| sx_ready_o | output | 1 | Simplex byte taken this cycle if valid |
| ct_data_i | input | 8 | Control channel byte |
| ct_valid_i | input | 1 | Control channel byte available |
| ct_ready_o | output | 1 | Control byte taken this cycle if valid |
| dx_data_i | input | 8 | Duplex channel byte |
| dx_valid_i | input | 1 | Duplex channel byte available |
| dx_ready_o | output | 1 | Duplex byte taken this cycle if valid |
| ovh_fast_i | input | 8 | CRC/indicator byte for the fast overhead position |
| ovh_intl_i | input | 8 | CRC/indicator byte for the interleaved overhead position |
| byte_o | output | 8 | Output stream byte |
| byte_valid_o | output | 1 | byte_o holds a stream byte |
| frame_start_o | output | 1 | First byte of a frame |
| sf_start_o | output | 1 | First byte of frame 0 |
| sync_frame_o | output | 1 | Byte belongs to the synchronisation frame |
| underrun_o | output | 1 | Sticky: a due payload byte was missing |

## Verification
The assertions assume that the sources hold data steady in any cycle where they see ready. They also assume that the side-input overhead bytes do not change inside a frame slot. The bench meets both by changing inputs only on the falling edge between frames. It spaces frame ticks at least 62 clocks apart, which covers the 59-byte frame plus the pipeline. The one early tick it sends falls inside a running frame, because that case is the one to be shown as ignored. The channel sources keep valid high at all times, except in one deliberately starved frame. That frame exercises the fill and underrun path.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic [2:0] {
    SK_OVH_FAST,
    SK_DUPLEX,
    SK_TAIL_L,
    SK_OVH_INTL,
    SK_SIMPLEX,
    SK_CTRL,
    SK_TAIL_A
  } slot_e;
endpackage

// File: rtl/sfm_slot_decode.sv
module sfm_slot_decode
  import sfm_pkg::*;
#(
  parameter int FAST_BYTES = 5,
  parameter int INTL_BYTES = 48,
  parameter int POS_W      = 6
) (
  input  logic [POS_W-1:0] pos_i,
  output slot_e            kind_o
);
  localparam logic [POS_W-1:0] P_DX_END  = POS_W'(FAST_BYTES);
  localparam logic [POS_W-1:0] P_TAIL_F  = POS_W'(FAST_BYTES + 1);
  localparam logic [POS_W-1:0] P_OVH_I   = POS_W'(FAST_BYTES + 2);
  localparam logic [POS_W-1:0] P_SX_END  = POS_W'(FAST_BYTES + 2 + INTL_BYTES);
  localparam logic [POS_W-1:0] P_CTRL    = POS_W'(FAST_BYTES + 3 + INTL_BYTES);
  localparam logic [POS_W-1:0] P_TAIL_A  = POS_W'(FAST_BYTES + 4 + INTL_BYTES);

  always_comb begin
    if (pos_i == '0)              kind_o = SK_OVH_FAST;
    else if (pos_i <= P_DX_END)   kind_o = SK_DUPLEX;
    else if (pos_i == P_TAIL_F)   kind_o = SK_TAIL_L;
    else if (pos_i == P_OVH_I)    kind_o = SK_OVH_INTL;
    else if (pos_i <= P_SX_END)   kind_o = SK_SIMPLEX;
    else if (pos_i == P_CTRL)     kind_o = SK_CTRL;
    else if (pos_i == P_TAIL_A)   kind_o = SK_TAIL_A;
    else                          kind_o = SK_TAIL_L;
  end
endmodule

// File: rtl/sfm_frame_seq.sv
module sfm_frame_seq #(
  parameter int FRAME_LEN = 59,
  parameter int FRAMES    = 69,
  parameter int POS_W     = 6,
  parameter int FNUM_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  output logic              busy_o,
  output logic [POS_W-1:0]  pos_o,
  output logic [FNUM_W-1:0] fnum_o
);
  localparam logic [POS_W-1:0]  P_LAST = POS_W'(FRAME_LEN - 1);
  localparam logic [FNUM_W-1:0] F_LAST = FNUM_W'(FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      pos_o  <= '0;
      fnum_o <= '0;
    end else if (!busy_o) begin
      if (tick_i) begin
        busy_o <= 1'b1;
        pos_o  <= '0;
      end
    end else if (pos_o == P_LAST) begin
      busy_o <= 1'b0;
      pos_o  <= '0;
      fnum_o <= (fnum_o == F_LAST) ? '0 : fnum_o + 1'b1;
    end else begin
      pos_o <= pos_o + 1'b1;
    end
  end
endmodule

// File: rtl/sf_mux.sv
module sf_mux
  import sfm_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          FAST_BYTES  = 5,
  parameter int          INTL_BYTES  = 48,
  parameter int          DATA_FRAMES = 68,
  parameter logic [7:0]  SYNC_FILL   = 8'h3C,
  parameter logic [7:0]  TAIL_A_BYTE = 8'hA5,
  parameter logic [7:0]  TAIL_L_BYTE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick_i,
  input  logic [DATA_W-1:0] sx_data_i,
  input  logic              sx_valid_i,
  output logic              sx_ready_o,
  input  logic [DATA_W-1:0] ct_data_i,
  input  logic              ct_valid_i,
  output logic              ct_ready_o,
  input  logic [DATA_W-1:0] dx_data_i,
  input  logic              dx_valid_i,
  output logic              dx_ready_o,
  input  logic [DATA_W-1:0] ovh_fast_i,
  input  logic [DATA_W-1:0] ovh_intl_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              frame_start_o,
  output logic              sf_start_o,
  output logic              sync_frame_o,
  output logic              underrun_o
);
  localparam int FRAME_LEN = FAST_BYTES + INTL_BYTES + 6;
  localparam int FRAMES    = DATA_FRAMES + 1;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int FNUM_W    = $clog2(FRAMES);
  localparam int HALF      = DATA_FRAMES / 2;
  localparam logic [FNUM_W-1:0] F_SYNC = FNUM_W'(DATA_FRAMES);
  localparam logic [FNUM_W-1:0] F_H0   = FNUM_W'(HALF);
  localparam logic [FNUM_W-1:0] F_H1   = FNUM_W'(HALF + 1);

  logic              busy;
  logic [POS_W-1:0]  pos;
  logic [FNUM_W-1:0] fnum;
  slot_e             kind;

  sfm_frame_seq #(
    .FRAME_LEN(FRAME_LEN), .FRAMES(FRAMES), .POS_W(POS_W), .FNUM_W(FNUM_W)
  ) u_seq (
    .clk(clk), .rst(rst), .tick_i(frame_tick_i),
    .busy_o(busy), .pos_o(pos), .fnum_o(fnum)
  );

  sfm_slot_decode #(
    .FAST_BYTES(FAST_BYTES), .INTL_BYTES(INTL_BYTES), .POS_W(POS_W)
  ) u_dec (
    .pos_i(pos), .kind_o(kind)
  );

  logic sync_fr, ovh_fr, ctrl_due;
  assign sync_fr  = (fnum == F_SYNC);
  assign ovh_fr   = (fnum == '0) || (fnum == FNUM_W'(1)) || (fnum == F_H0) || (fnum == F_H1);
  assign ctrl_due = ~fnum[0];

  logic [DATA_W-1:0] nxt;
  logic              due, have;

  always_comb begin
    sx_ready_o = 1'b0;
    ct_ready_o = 1'b0;
    dx_ready_o = 1'b0;
    nxt        = '0;
    due        = 1'b0;
    have       = 1'b0;
    if (busy && !sync_fr) begin
      case (kind)
        SK_OVH_FAST: nxt = ovh_fr ? ovh_fast_i : SYNC_FILL;
        SK_OVH_INTL: nxt = ovh_fr ? ovh_intl_i : SYNC_FILL;
        SK_DUPLEX: begin
          dx_ready_o = 1'b1;
          due        = 1'b1;
          have       = dx_valid_i;
          nxt        = dx_valid_i ? dx_data_i : '0;
        end
        SK_SIMPLEX: begin
          sx_ready_o = 1'b1;
          due        = 1'b1;
          have       = sx_valid_i;
          nxt        = sx_valid_i ? sx_data_i : '0;
        end
        SK_CTRL: begin
          if (ctrl_due) begin
            ct_ready_o = 1'b1;
            due        = 1'b1;
            have       = ct_valid_i;
            nxt        = ct_valid_i ? ct_data_i : '0;
          end
        end
        SK_TAIL_A: nxt = TAIL_A_BYTE;
        SK_TAIL_L: nxt = TAIL_L_BYTE;
        default:   nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_o        <= '0;
      byte_valid_o  <= 1'b0;
      frame_start_o <= 1'b0;
      sf_start_o    <= 1'b0;
      sync_frame_o  <= 1'b0;
      underrun_o    <= 1'b0;
    end else begin
      byte_o        <= nxt;
      byte_valid_o  <= busy;
      frame_start_o <= busy && (pos == '0);
      sf_start_o    <= busy && (pos == '0) && (fnum == '0);
      sync_frame_o  <= busy && sync_fr;
      if (due && !have) underrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sf_mux_chk.sv
module sf_mux_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] sx_data_i,
  input logic       sx_valid_i,
  input logic       sx_ready_o,
  input logic [7:0] dx_data_i,
  input logic       dx_valid_i,
  input logic       dx_ready_o,
  input logic       ct_ready_o,
  input logic [7:0] byte_o,
  input logic       byte_valid_o,
  input logic       frame_start_o,
  input logic       sf_start_o,
  input logic       sync_frame_o,
  input logic       underrun_o
);
  p_ready_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sx_ready_o, ct_ready_o, dx_ready_o}));

  p_sx_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (sx_ready_o && sx_valid_i) |=> (byte_valid_o && byte_o == $past(sx_data_i)));

  p_dx_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (dx_ready_o && dx_valid_i) |=> (byte_valid_o && byte_o == $past(dx_data_i)));

  p_sync_zero_r7: assert property (@(posedge clk) disable iff (rst)
    sync_frame_o |-> (byte_valid_o && byte_o == 8'h00));

  p_sf_marks_frame_r8: assert property (@(posedge clk) disable iff (rst)
    sf_start_o |-> frame_start_o);

  p_fstart_single_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> (byte_valid_o && !frame_start_o));

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    underrun_o |=> underrun_o);

  p_starve_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (sx_ready_o && !sx_valid_i) |=> (underrun_o && byte_o == 8'h00));
endmodule

bind sf_mux sf_mux_chk u_chk (
  .clk(clk), .rst(rst),
  .sx_data_i(sx_data_i), .sx_valid_i(sx_valid_i), .sx_ready_o(sx_ready_o),
  .dx_data_i(dx_data_i), .dx_valid_i(dx_valid_i), .dx_ready_o(dx_ready_o),
  .ct_ready_o(ct_ready_o),
  .byte_o(byte_o), .byte_valid_o(byte_valid_o),
  .frame_start_o(frame_start_o), .sf_start_o(sf_start_o),
  .sync_frame_o(sync_frame_o), .underrun_o(underrun_o)
);

// File: tb/sf_mux_tb.sv
module sf_mux_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick_i = 1'b0;
  logic [7:0] sx_data_i, ct_data_i, dx_data_i;
  logic sx_valid_i, ct_valid_i, dx_valid_i;
  logic sx_ready_o, ct_ready_o, dx_ready_o;
  logic [7:0] ovh_fast_i = 8'h00;
  logic [7:0] ovh_intl_i = 8'h00;
  logic [7:0] byte_o;
  logic byte_valid_o, frame_start_o, sf_start_o, sync_frame_o, underrun_o;

  always #2.5 clk = ~clk;

  sf_mux u_dut (
    .clk(clk), .rst(rst), .frame_tick_i(frame_tick_i),
    .sx_data_i(sx_data_i), .sx_valid_i(sx_valid_i), .sx_ready_o(sx_ready_o),
    .ct_data_i(ct_data_i), .ct_valid_i(ct_valid_i), .ct_ready_o(ct_ready_o),
    .dx_data_i(dx_data_i), .dx_valid_i(dx_valid_i), .dx_ready_o(dx_ready_o),
    .ovh_fast_i(ovh_fast_i), .ovh_intl_i(ovh_intl_i),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .frame_start_o(frame_start_o), .sf_start_o(sf_start_o),
    .sync_frame_o(sync_frame_o), .underrun_o(underrun_o)
  );

  // Channel sources: counting byte patterns, advanced on handshake
  logic [7:0] sx_cnt, ct_cnt, dx_cnt;
  logic sx_starve = 1'b0;
  assign sx_data_i  = sx_cnt;
  assign ct_data_i  = ct_cnt;
  assign dx_data_i  = dx_cnt;
  assign sx_valid_i = !sx_starve;
  assign ct_valid_i = 1'b1;
  assign dx_valid_i = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      sx_cnt <= 8'h00;
      ct_cnt <= 8'hC0;
      dx_cnt <= 8'h40;
    end else begin
      if (sx_valid_i && sx_ready_o) sx_cnt <= sx_cnt + 8'd1;
      if (ct_valid_i && ct_ready_o) ct_cnt <= ct_cnt + 8'd1;
      if (dx_valid_i && dx_ready_o) dx_cnt <= dx_cnt + 8'd1;
    end
  end

  typedef struct {
    logic [7:0] b;
    logic fs, sfs, sy;
    string req;
  } item_t;
  item_t q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int exp_sx = 8'h00;
  int exp_ct = 8'hC0;
  int exp_dx = 8'h40;

  task automatic push(input logic [7:0] b, input logic fs, input logic sfs,
                      input logic sy, input string req);
    item_t it;
    it.b = b; it.fs = fs; it.sfs = sfs; it.sy = sy; it.req = req;
    q.push_back(it);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: expected bytes for frame number fi, computed from the requirements
  task automatic expect_frame(input int fi, input bit starve);
    bit ovh;
    ovh = (fi == 0) || (fi == 1) || (fi == 34) || (fi == 35);
    if (fi == 68) begin
      for (int i = 0; i < 59; i++) push(8'h00, i == 0, 1'b0, 1'b1, "R7");
      return;
    end
    push(ovh ? 8'(8'h10 + fi) : 8'h3C, 1'b1, fi == 0, 1'b0, (fi == 0) ? "R8" : "R6");
    for (int i = 0; i < 5; i++) begin
      push(8'(exp_dx), 1'b0, 1'b0, 1'b0, "R3");
      exp_dx++;
    end
    push(8'h5A, 1'b0, 1'b0, 1'b0, "R3");
    push(ovh ? 8'(8'h50 + fi) : 8'h3C, 1'b0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 48; i++) begin
      if (starve) push(8'h00, 1'b0, 1'b0, 1'b0, "R9");
      else begin
        push(8'(exp_sx), 1'b0, 1'b0, 1'b0, "R4");
        exp_sx++;
      end
    end
    if ((fi % 2) == 0) begin
      push(8'(exp_ct), 1'b0, 1'b0, 1'b0, "R5");
      exp_ct++;
    end else begin
      push(8'h00, 1'b0, 1'b0, 1'b0, "R5");
    end
    push(8'hA5, 1'b0, 1'b0, 1'b0, "R4");
    push(8'h5A, 1'b0, 1'b0, 1'b0, "R4");
  endtask

  // Monitor: pops and compares on the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if ($countones({sx_ready_o, ct_ready_o, dx_ready_o}) > 1)
        chk(1'b0, "R10", {sx_ready_o, ct_ready_o, dx_ready_o}, 0);
      if (byte_valid_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", byte_o, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(byte_o == it.b, it.req, byte_o, it.b);
          chk({frame_start_o, sf_start_o, sync_frame_o} == {it.fs, it.sfs, it.sy},
              (it.sy ? "R7" : (it.fs ? "R2" : it.req)),
              {frame_start_o, sf_start_o, sync_frame_o}, {it.fs, it.sfs, it.sy});
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!byte_valid_o && !underrun_o, "R1", {byte_valid_o, underrun_o}, 0);
    chk(!sx_ready_o && !ct_ready_o && !dx_ready_o, "R1",
        {sx_ready_o, ct_ready_o, dx_ready_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!byte_valid_o, "R1", byte_valid_o, 0);
    for (int k = 0; k < 72; k++) begin
      int fi;
      bit st;
      fi = k % 69;
      st = (k == 5);
      if (k == 5) chk(underrun_o == 1'b0, "R9", underrun_o, 0);
      sx_starve  = st;
      ovh_fast_i = 8'(8'h10 + fi);
      ovh_intl_i = 8'(8'h50 + fi);
      expect_frame(fi, st);
      frame_tick_i = 1'b1;
      @(negedge clk);
      frame_tick_i = 1'b0;
      for (int c = 0; c < 62; c++) begin
        @(negedge clk);
        // R2: a tick in the middle of a frame must be ignored
        if (k == 3 && c == 20) frame_tick_i = 1'b1;
        if (k == 3 && c == 21) frame_tick_i = 1'b0;
      end
      if (k == 5) chk(underrun_o == 1'b1, "R9", underrun_o, 1);
    end
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R2", q.size(), 0);
    chk(underrun_o == 1'b1, "R9", underrun_o, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired R2 actual=%0h expected=%0h", q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule